// File: doc/BRIEF.md
# Outbound Address Translation Window Table

This block maps addresses issued by a processor-side master onto addresses for a downstream PCIe link. It holds a small table of windows. Each window has an enable, a size that is a power of two, a 64-bit source base, a 64-bit target base, and a pair of request-type fields that tell the transaction layer whether to issue a memory or an I/O request. The table is written and read back through a simple 32-bit register port.

On the lookup side the block takes an address with a valid strobe. One clock later it returns a valid flag, a hit flag, the index of the matching window, the translated address and the two type fields. A miss means the request must be rejected upstream. When several enabled windows cover the same address, the lowest-numbered window decides.

Top module: `oxw_xlat_top`

## Requirements
- R1: While reset is asserted, and after it is released, every window is disabled and all table fields read as zero. `rsp_valid`, `rsp_hit` and `reg_rdata` are 0, and every lookup misses until a window is programmed.
- R2: Window n sits at byte address 0x800 + 0x20*n, with n from 0 to 7. Its words are:
  - +0x0: bit 0 is the enable, bits 6:1 are the size code, and bits 31:7 are source address bits 31:7.
  - +0x4: source address bits 63:32.
  - +0x8: target address bits 31:0.
  - +0xC: target address bits 63:32.
  - +0x10: bits 3:0 are a request-kind code (0 memory, 1 I/O) and bits 18:16 are a transaction-type code (0 memory, 2 I/O). All other bits of this word read as zero.

  A read returns the word on `reg_rdata` one cycle after `reg_en` with `reg_we` low.
- R3: Several register accesses are ignored: an address outside 0x800 to 0x8FF, an address whose bits 1:0 are not zero, or a window word offset from +0x14 to +0x1C. Writes to such addresses change no window, and reads of them return zero.
- R4: A window whose enable bit is 0 never produces a hit, whatever its other fields hold.
- R5: A window with size code f covers 2^(f+1) bytes. An address matches when its bits 63:f+1 equal those of the source base. The source base bits 6:0 are always taken as zero. A code of 63 covers the whole address space.
- R6: On a hit, `rsp_addr` equals the target base plus (address mod 2^(f+1)), with the sum taken modulo 2^64. The carry is allowed to pass into the upper word.
- R7: When more than one enabled window matches, the one with the lowest index is reported, and its fields are used.
- R8: On a miss, `rsp_hit`, `rsp_win`, `rsp_addr`, `rsp_kind` and `rsp_tlp` are all zero.
- R9: `rsp_valid` is high exactly one cycle after each cycle in which `lk_valid` is high. The response fields change only after a lookup and otherwise hold their last values.
- R10: A lookup presented in the same cycle as a table write sees the table as it was before that write. The next lookup sees the new contents.
- R11: On a hit, `rsp_kind` and `rsp_tlp` carry the request-kind and transaction-type codes of the reporting window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; internally released on the clock |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 64 | Address to translate |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | An enabled window matched |
| rsp_win | output | 3 | Index of the reporting window |
| rsp_addr | output | 64 | Translated address |
| rsp_kind | output | 4 | Request-kind code of the reporting window |
| rsp_tlp | output | 3 | Transaction-type code of the reporting window |

## Verification
The properties assume that `lk_valid`, `reg_en` and `reg_we` are always known values. They also assume that the response is judged against the window enables as they stood in the cycle of the lookup, not after a write in that same cycle.

The bench changes all inputs on the falling clock edge, so every request and every table write is seen at exactly one rising edge. It keeps the strobes low while reset is active and during the two cycles in which the internal reset is released. It only overlaps a write with a lookup in the one test built to probe that ordering.

// File: rtl/oxw_pkg.sv
package oxw_pkg;
  localparam int unsigned XA_W          = 64;
  localparam int unsigned REG_DW        = 32;
  localparam int unsigned SZ_W          = 6;
  localparam int unsigned KIND_W        = 4;
  localparam int unsigned TLP_W         = 3;
  localparam int unsigned TLP_LSB       = 16;
  localparam int unsigned SRC_LSB       = SZ_W + 1;
  localparam int unsigned WIN_STRIDE_LG = 5;
  localparam int unsigned WORD_W        = WIN_STRIDE_LG - 2;

  typedef enum logic [WORD_W-1:0] {
    WD_SRC_LO = 3'd0,
    WD_SRC_HI = 3'd1,
    WD_DST_LO = 3'd2,
    WD_DST_HI = 3'd3,
    WD_PARAM  = 3'd4
  } wword_e;

  typedef struct packed {
    logic                    en;
    logic [SZ_W-1:0]         szlog;
    logic [XA_W-1:SRC_LSB]   src;
    logic [XA_W-1:0]         dst;
    logic [KIND_W-1:0]       kind;
    logic [TLP_W-1:0]        tlp;
  } wcfg_t;

  // Offset mask of a window: ones on the bits that lie inside the window.
  function automatic logic [XA_W-1:0] span_mask(input logic [SZ_W-1:0] f);
    logic [SZ_W:0] sh;
    sh = {1'b0, f} + (SZ_W+1)'(1);
    return ~({XA_W{1'b1}} << sh);
  endfunction
endpackage

// File: rtl/oxw_rst_sync.sv
module oxw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/oxw_regfile.sv
module oxw_regfile
  import oxw_pkg::*;
#(
  parameter int unsigned NUM_WIN = 8,
  parameter int unsigned REG_AW  = 12,
  parameter logic [REG_AW-1:0] TBL_BASE = 12'h800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output wcfg_t             cfg [NUM_WIN]
);
  localparam int unsigned WIN_IW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam int unsigned TBL_LG = WIN_STRIDE_LG + WIN_IW;
  localparam logic [REG_AW-TBL_LG-1:0] TBL_TAG = TBL_BASE[REG_AW-1:TBL_LG];

  logic [WORD_W-1:0] word_idx;
  logic [WIN_IW-1:0] win_idx;
  logic              in_tbl;
  logic              wr_hit;
  logic              rd_hit;
  logic              word_ok;

  assign word_idx = reg_addr[WIN_STRIDE_LG-1:2];
  assign win_idx  = reg_addr[WIN_STRIDE_LG +: WIN_IW];
  assign word_ok  = (word_idx <= WD_PARAM);
  assign in_tbl   = (reg_addr[REG_AW-1:TBL_LG] == TBL_TAG) &&
                    (reg_addr[1:0] == 2'b00) && word_ok;
  assign wr_hit   = reg_en & reg_we & in_tbl;
  assign rd_hit   = reg_en & ~reg_we;

  wcfg_t cfg_q [NUM_WIN];
  wcfg_t cfg_d [NUM_WIN];
  logic  cfg_ld [NUM_WIN];

  for (genvar n = 0; n < NUM_WIN; n++) begin : g_win
    assign cfg_ld[n] = wr_hit && (win_idx == WIN_IW'(n));

    always_comb begin
      cfg_d[n] = cfg_q[n];
      case (word_idx)
        WD_SRC_LO: begin
          cfg_d[n].en                     = reg_wdata[0];
          cfg_d[n].szlog                  = reg_wdata[SZ_W:1];
          cfg_d[n].src[REG_DW-1:SRC_LSB]  = reg_wdata[REG_DW-1:SRC_LSB];
        end
        WD_SRC_HI: cfg_d[n].src[XA_W-1:REG_DW] = reg_wdata;
        WD_DST_LO: cfg_d[n].dst[REG_DW-1:0]    = reg_wdata;
        WD_DST_HI: cfg_d[n].dst[XA_W-1:REG_DW] = reg_wdata;
        WD_PARAM: begin
          cfg_d[n].kind = reg_wdata[KIND_W-1:0];
          cfg_d[n].tlp  = reg_wdata[TLP_LSB +: TLP_W];
        end
        default: ;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cfg_q[n] <= '0;
      else if (cfg_ld[n])  cfg_q[n] <= cfg_d[n];
    end

    assign cfg[n] = cfg_q[n];
  end

  wcfg_t             sel;
  logic [REG_DW-1:0] rd_word;

  always_comb begin
    sel     = cfg_q[win_idx];
    rd_word = '0;
    if (in_tbl) begin
      case (word_idx)
        WD_SRC_LO: rd_word = {sel.src[REG_DW-1:SRC_LSB], sel.szlog, sel.en};
        WD_SRC_HI: rd_word = sel.src[XA_W-1:REG_DW];
        WD_DST_LO: rd_word = sel.dst[REG_DW-1:0];
        WD_DST_HI: rd_word = sel.dst[XA_W-1:REG_DW];
        WD_PARAM: begin
          rd_word[KIND_W-1:0]        = sel.kind;
          rd_word[TLP_LSB +: TLP_W]  = sel.tlp;
        end
        default: rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       reg_rdata <= '0;
    else if (rd_hit)  reg_rdata <= rd_word;
  end
endmodule

// File: rtl/oxw_match.sv
module oxw_match
  import oxw_pkg::*;
#(
  parameter int unsigned NUM_WIN = 8
) (
  input  logic [NUM_WIN-1:0] en_vec,
  input  logic [SZ_W-1:0]    szlog   [NUM_WIN],
  input  logic [XA_W-1:0]    src_base[NUM_WIN],
  input  logic [XA_W-1:0]    lk_addr,
  output logic [NUM_WIN-1:0] hit_vec,
  output logic [XA_W-1:0]    off_mask[NUM_WIN]
);
  for (genvar n = 0; n < NUM_WIN; n++) begin : g_cmp
    assign off_mask[n] = span_mask(szlog[n]);
    assign hit_vec[n]  = en_vec[n] &&
                         (((lk_addr ^ src_base[n]) & ~off_mask[n]) == '0);
  end
endmodule

// File: rtl/oxw_resp.sv
module oxw_resp
  import oxw_pkg::*;
#(
  parameter int unsigned NUM_WIN = 8,
  localparam int unsigned WIN_IW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [XA_W-1:0]    lk_addr,
  input  logic [NUM_WIN-1:0] hit_vec,
  input  logic [XA_W-1:0]    off_mask[NUM_WIN],
  input  logic [XA_W-1:0]    dst     [NUM_WIN],
  input  logic [KIND_W-1:0]  kind    [NUM_WIN],
  input  logic [TLP_W-1:0]   tlp     [NUM_WIN],
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [WIN_IW-1:0]  rsp_win,
  output logic [XA_W-1:0]    rsp_addr,
  output logic [KIND_W-1:0]  rsp_kind,
  output logic [TLP_W-1:0]   rsp_tlp
);
  logic              hit_d;
  logic [WIN_IW-1:0] win_d;
  logic [XA_W-1:0]   addr_d;
  logic [KIND_W-1:0] kind_d;
  logic [TLP_W-1:0]  tlp_d;

  // Priority pick: scanning downward leaves the lowest matching index.
  always_comb begin
    hit_d = 1'b0;
    win_d = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit_d = 1'b1;
        win_d = WIN_IW'(i);
      end
    end
  end

  // One shared adder after the window mux.
  always_comb begin
    addr_d = '0;
    kind_d = '0;
    tlp_d  = '0;
    if (hit_d) begin
      addr_d = dst[win_d] + (lk_addr & off_mask[win_d]);
      kind_d = kind[win_d];
      tlp_d  = tlp[win_d];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= lk_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_hit  <= 1'b0;
      rsp_win  <= '0;
      rsp_addr <= '0;
      rsp_kind <= '0;
      rsp_tlp  <= '0;
    end else if (lk_valid) begin
      rsp_hit  <= hit_d;
      rsp_win  <= win_d;
      rsp_addr <= addr_d;
      rsp_kind <= kind_d;
      rsp_tlp  <= tlp_d;
    end
  end
endmodule

// File: rtl/oxw_xlat_top.sv
module oxw_xlat_top
  import oxw_pkg::*;
#(
  parameter int unsigned NUM_WIN = 8,
  parameter int unsigned REG_AW  = 12,
  parameter logic [REG_AW-1:0] TBL_BASE = 12'h800,
  localparam int unsigned WIN_IW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              lk_valid,
  input  logic [XA_W-1:0]   lk_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WIN_IW-1:0] rsp_win,
  output logic [XA_W-1:0]   rsp_addr,
  output logic [KIND_W-1:0] rsp_kind,
  output logic [TLP_W-1:0]  rsp_tlp
);
  logic rst_q_n;

  oxw_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  wcfg_t cfg [NUM_WIN];

  oxw_regfile #(
    .NUM_WIN  (NUM_WIN),
    .REG_AW   (REG_AW),
    .TBL_BASE (TBL_BASE)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cfg       (cfg)
  );

  logic [NUM_WIN-1:0] en_vec;
  logic [SZ_W-1:0]    szlog   [NUM_WIN];
  logic [XA_W-1:0]    src_base[NUM_WIN];
  logic [XA_W-1:0]    dst     [NUM_WIN];
  logic [KIND_W-1:0]  kind    [NUM_WIN];
  logic [TLP_W-1:0]   tlp     [NUM_WIN];

  for (genvar n = 0; n < NUM_WIN; n++) begin : g_split
    assign en_vec[n]   = cfg[n].en;
    assign szlog[n]    = cfg[n].szlog;
    assign src_base[n] = {cfg[n].src, {SRC_LSB{1'b0}}};
    assign dst[n]      = cfg[n].dst;
    assign kind[n]     = cfg[n].kind;
    assign tlp[n]      = cfg[n].tlp;
  end

  logic [NUM_WIN-1:0] hit_vec;
  logic [XA_W-1:0]    off_mask[NUM_WIN];

  oxw_match #(.NUM_WIN(NUM_WIN)) u_match (
    .en_vec   (en_vec),
    .szlog    (szlog),
    .src_base (src_base),
    .lk_addr  (lk_addr),
    .hit_vec  (hit_vec),
    .off_mask (off_mask)
  );

  oxw_resp #(.NUM_WIN(NUM_WIN)) u_resp (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .lk_valid  (lk_valid),
    .lk_addr   (lk_addr),
    .hit_vec   (hit_vec),
    .off_mask  (off_mask),
    .dst       (dst),
    .kind      (kind),
    .tlp       (tlp),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_win   (rsp_win),
    .rsp_addr  (rsp_addr),
    .rsp_kind  (rsp_kind),
    .rsp_tlp   (rsp_tlp)
  );
endmodule

// File: rtl/oxw_xlat_chk.sv
module oxw_xlat_chk
  import oxw_pkg::*;
#(
  parameter int unsigned NUM_WIN = 8,
  parameter int unsigned REG_AW  = 12,
  parameter logic [REG_AW-1:0] TBL_BASE = 12'h800,
  localparam int unsigned WIN_IW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_en,
  input logic               reg_we,
  input logic [REG_AW-1:0]  reg_addr,
  input logic [REG_DW-1:0]  reg_rdata,
  input logic               lk_valid,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic [WIN_IW-1:0]  rsp_win,
  input logic [XA_W-1:0]    rsp_addr,
  input logic [KIND_W-1:0]  rsp_kind,
  input logic [TLP_W-1:0]   rsp_tlp,
  input logic [NUM_WIN-1:0] en_vec
);
  logic unmapped;
  logic param_rd;
  logic rd_req;

  assign rd_req   = reg_en && !reg_we;
  assign unmapped = (int'(reg_addr) < int'(TBL_BASE)) ||
                    (int'(reg_addr) >= int'(TBL_BASE) + int'(NUM_WIN) * 32) ||
                    (reg_addr[1:0] != 2'b00) || (reg_addr[4:2] > 3'd4);
  assign param_rd = !unmapped && (reg_addr[4:2] == 3'd4);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid) else $error("rsp_valid missing"); // R9
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid) else $error("rsp_valid without request"); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> ($stable(rsp_addr) && $stable(rsp_hit) && $stable(rsp_win))) else $error("response moved"); // R9
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_addr == '0 && rsp_win == '0 && rsp_kind == '0 && rsp_tlp == '0)) else $error("miss not zero"); // R8
  AST_ALL_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && en_vec == '0) |=> !rsp_hit) else $error("hit with no window on"); // R4
  AST_HIT_WIN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (!rsp_hit || (($past(en_vec) & (NUM_WIN'(1) << rsp_win)) != '0))) else $error("hit on disabled window"); // R4
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && unmapped) |=> (reg_rdata == '0)) else $error("unmapped read nonzero"); // R3
  AST_PARAM_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && param_rd) |=> ((reg_rdata & 32'hFFF8_FFF0) == '0)) else $error("reserved bits set"); // R2
endmodule

bind oxw_xlat_top oxw_xlat_chk #(
  .NUM_WIN  (NUM_WIN),
  .REG_AW   (REG_AW),
  .TBL_BASE (TBL_BASE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .reg_en    (reg_en),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .lk_valid  (lk_valid),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_win   (rsp_win),
  .rsp_addr  (rsp_addr),
  .rsp_kind  (rsp_kind),
  .rsp_tlp   (rsp_tlp),
  .en_vec    (en_vec)
);

// File: tb/sim_oxw_xlat_top.sv
`timescale 1ns/1ps
module sim_oxw_xlat_top;
  logic        clk;
  logic        rst_n;
  logic        reg_en;
  logic        reg_we;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        lk_valid;
  logic [63:0] lk_addr;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [2:0]  rsp_win;
  logic [63:0] rsp_addr;
  logic [3:0]  rsp_kind;
  logic [2:0]  rsp_tlp;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  oxw_xlat_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_win(rsp_win), .rsp_addr(rsp_addr),
    .rsp_kind(rsp_kind), .rsp_tlp(rsp_tlp)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [63:0] a;
    logic        h;
    logic [2:0]  w;
    logic [63:0] x;
    logic [3:0]  k;
    logic [2:0]  t;
  } vec_t;

  // Stimulus and expected results for the programmed table (R5 R6 R7 R8 R11).
  localparam vec_t VECS [11] = '{
    '{64'h0000_0001_0000_1234, 1'b1, 3'd0, 64'h0000_0000_8000_1234, 4'd0, 3'd0},
    '{64'h0000_0001_0001_0000, 1'b1, 3'd1, 64'h0000_0000_C001_0000, 4'd1, 3'd2},
    '{64'h0000_0001_000F_FFFF, 1'b1, 3'd1, 64'h0000_0000_C00F_FFFF, 4'd1, 3'd2},
    '{64'h0000_0001_0010_0000, 1'b0, 3'd0, 64'h0,                   4'd0, 3'd0},
    '{64'h0000_0000_4000_0010, 1'b0, 3'd0, 64'h0,                   4'd0, 3'd0},
    '{64'h0000_0000_0000_1000, 1'b1, 3'd3, 64'h0000_0002_FFFF_FFF0, 4'd1, 3'd2},
    '{64'h0000_0000_0000_107F, 1'b1, 3'd3, 64'h0000_0003_0000_006F, 4'd1, 3'd2},
    '{64'h0000_0000_0000_1080, 1'b0, 3'd0, 64'h0,                   4'd0, 3'd0},
    '{64'h0000_0000_0000_0FFF, 1'b0, 3'd0, 64'h0,                   4'd0, 3'd0},
    '{64'h0000_0001_0000_FFFF, 1'b1, 3'd0, 64'h0000_0000_8000_FFFF, 4'd0, 3'd0},
    '{64'h0000_0000_0000_0000, 1'b0, 3'd0, 64'h0,                   4'd0, 3'd0}
  };

  function automatic logic [11:0] wa(input int n, input int off);
    return 12'(32'h800 + n * 32 + off);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic look(input logic [63:0] a);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic check_rsp(input string req, input logic h, input logic [2:0] w,
                           input logic [63:0] x, input logic [3:0] k, input logic [2:0] t);
    check(req, "valid/hit/win/kind/tlp",
          64'({rsp_valid, rsp_hit, rsp_win, rsp_kind, rsp_tlp}),
          64'({1'b1, h, w, k, t}));
    check(req, "addr", rsp_addr, x);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; reg_en = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    lk_valid = 1'b0; lk_addr = '0;
    repeat (3) @(negedge clk);
    check("R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "rsp_hit after reset", 64'(rsp_hit), 64'd0);
    check("R1", "rdata after reset", 64'(reg_rdata), 64'd0);
    rd(wa(0, 0), d);
    check("R1", "window0 word0 after reset", 64'(d), 64'd0);
    look(64'h1000);
    check_rsp("R1", 1'b0, 3'd0, 64'h0, 4'd0, 3'd0);

    // Program the table (R2 layout).
    wr(wa(0, 'h0), 32'h0000_001F); wr(wa(0, 'h4), 32'h1);
    wr(wa(0, 'h8), 32'h8000_0000); wr(wa(0, 'hC), 32'h0);
    wr(wa(1, 'h0), 32'h0000_0027); wr(wa(1, 'h4), 32'h1);
    wr(wa(1, 'h8), 32'hC000_0000); wr(wa(1, 'h10), 32'h0002_0001);
    wr(wa(2, 'h0), 32'h4000_0016); wr(wa(2, 'h8), 32'h1234_0000);
    wr(wa(3, 'h0), 32'h0000_100D); wr(wa(3, 'h8), 32'hFFFF_FFF0);
    wr(wa(3, 'hC), 32'h2);         wr(wa(3, 'h10), 32'h0002_0001);

    // Vector table walk.
    for (int i = 0; i < 11; i++) begin
      look(VECS[i].a);
      check_rsp(VECS[i].h ? "R5/R6/R7/R11 hit" : "R8 miss",
                VECS[i].h, VECS[i].w, VECS[i].x, VECS[i].k, VECS[i].t);
    end

    // R2 readback.
    rd(wa(1, 'h0), d);  check("R2", "w1 word0", 64'(d), 64'h27);
    rd(wa(1, 'h4), d);  check("R2", "w1 word4", 64'(d), 64'h1);
    rd(wa(3, 'h0), d);  check("R2", "w3 word0", 64'(d), 64'h100D);
    rd(wa(3, 'hC), d);  check("R2", "w3 wordC", 64'(d), 64'h2);
    rd(wa(1, 'h10), d); check("R2", "w1 param", 64'(d), 64'h0002_0001);
    wr(wa(0, 'h10), 32'hFFFF_FFFF);
    rd(wa(0, 'h10), d); check("R2", "param keeps only fields", 64'(d), 64'h0007_000F);
    wr(wa(0, 'h10), 32'h0);

    // R3 ignored accesses.
    wr(wa(0, 'h14), 32'hFFFF_FFFF);
    rd(wa(0, 'h14), d); check("R3", "offset 0x14 read", 64'(d), 64'h0);
    wr(12'h7FC, 32'hFFFF_FFFF);
    rd(12'h7FC, d);     check("R3", "below table read", 64'(d), 64'h0);
    wr(12'h900, 32'hFFFF_FFFF);
    rd(12'h900, d);     check("R3", "above table read", 64'(d), 64'h0);
    wr(12'h801, 32'h0);
    rd(wa(0, 'h0), d);  check("R3", "unaligned write ignored", 64'(d), 64'h1F);
    look(64'h0000_0001_0000_1234);
    check_rsp("R3", 1'b1, 3'd0, 64'h8000_1234, 4'd0, 3'd0);

    // R4 enabling a window.
    wr(wa(2, 'h0), 32'h4000_0017);
    look(64'h4000_0010);
    check_rsp("R4", 1'b1, 3'd2, 64'h1234_0010, 4'd0, 3'd0);

    // R10 write and lookup in the same cycle.
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = wa(2, 'h0); reg_wdata = 32'h4000_0016;
    lk_valid = 1'b1; lk_addr = 64'h4000_0010;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0; lk_valid = 1'b0;
    check_rsp("R10", 1'b1, 3'd2, 64'h1234_0010, 4'd0, 3'd0);
    look(64'h4000_0010);
    check_rsp("R10", 1'b0, 3'd0, 64'h0, 4'd0, 3'd0);

    // R9 hold without request.
    look(64'h1000);
    repeat (3) @(negedge clk);
    check("R9", "valid drops", 64'(rsp_valid), 64'd0);
    check("R9", "addr held", rsp_addr, 64'h0000_0002_FFFF_FFF0);

    // R5/R6 whole-space window with wrap, R7 priority over it.
    wr(wa(7, 'h0), 32'h0000_007F); wr(wa(7, 'h8), 32'h10);
    look(64'hFFFF_FFFF_FFFF_FFF0);
    check_rsp("R6", 1'b1, 3'd7, 64'h0, 4'd0, 3'd0);
    look(64'h0);
    check_rsp("R5", 1'b1, 3'd7, 64'h10, 4'd0, 3'd0);
    look(64'h1000);
    check_rsp("R7", 1'b1, 3'd3, 64'h0000_0002_FFFF_FFF0, 4'd1, 3'd2);

    // R1 reset clears the table.
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    look(64'h1000);
    check_rsp("R1", 1'b0, 3'd0, 64'h0, 4'd0, 3'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule